// File: doc/BRIEF.md
# Complex-Access Register Bank

This block is a small memory-mapped register bank on a single-cycle word bus. Each cycle the bus gives an address, a write enable, a read enable and write data. Read data comes back from a register one cycle later. Several of the registers do more than plain read and write.

- **Configuration register and its shadow.** A write-only configuration register copies every write into a shadow. Software reads the shadow to see what it wrote.
- **Interrupt flags.** One physical set of interrupt flags appears at two addresses. One address is a read-only view. The other is a write-1-to-clear view. Application hardware sets the flags.
- **Protected register.** This register accepts bus writes only while no lock is active. The lock comes from a control bit, an external input, or both.
- **Shared offset 3.** A read-only status word and a write-only transmit word both sit at offset 3.

The application side drives interrupt set pulses, the status word and the hardware lock. It receives the configuration word and the transmit word.

Top module: `complexRegBank`

## Requirements
- R1: After reset every register holds zero, `cfgWord` and `txWord` are zero, and reads of offsets 1, 2 and 6 return zero.
- R2: A write to offset 0 updates `cfgWord` and the shadow at the same clock edge with the same data. Reading offset 0 returns zero. Reading offset 1 returns the shadow.
- R3: Bus writes to offset 1 leave the shadow unchanged.
- R4: A 1 on any bit of `irqSet` sets that flag bit. Reads of offset 2 and of offset 4 both return the flags. Bus writes to offset 2 do not change them.
- R5: A write to offset 4 clears each flag bit where the write data holds a 1. All other flag bits are unchanged.
- R6: If `irqSet` and a clear at offset 4 hit the same bit in one cycle, the bit ends up set.
- R7: Offset 5 is a 32-bit read/write lock control register, and its bit 0 is the lock field. Writes to it are always accepted, even while the lock is active.
- R8: Offset 6 is read/write. A write to it is ignored when lock field bit 0 is 1 or `hwLock` is high in the write cycle. Otherwise the write is accepted.
- R9: A read at offset 3 returns `statusIn` as sampled in the request cycle. A write at offset 3 updates only `txWord`, and that value never appears on read data.
- R10: Offsets 7 to 15 read as zero. Writes to them change no register or output.
- R11: `busRdData` takes its new value at the edge that samples `busRdEn`. It holds that value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 4 | Word address |
| busWrEn | input | 1 | Write request |
| busRdEn | input | 1 | Read request |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| irqSet | input | 32 | Per-bit interrupt set pulses |
| statusIn | input | 32 | Status word for offset 3 reads |
| hwLock | input | 1 | External lock for offset 6 |
| cfgWord | output | 32 | Configuration register value |
| txWord | output | 32 | Transmit register value |

## Verification
The interrupt flags are driven with three patterns:
- a set pulse alone, which shows that both alias views report the same flags;
- a partial write-1 clear, which shows that clearing works per bit;
- a set and a full clear in the same cycle, which shows the priority order.

The lock is tried with the control bit only, then with the external input only, and then with the control bit cleared while it was locked. This separates the two lock sources and shows that the control register itself is never blocked. Writes to offset 3, to the shadow, to the read-only flag view and to unmapped offsets are each followed by reads of every register they could touch.

// File: rtl/regBankPkg.sv
package regBankPkg;
  localparam int OFS_ORIG    = 0;
  localparam int OFS_SHADOW  = 1;
  localparam int OFS_IRQ_RO  = 2;
  localparam int OFS_PAIR    = 3;
  localparam int OFS_IRQ_W1C = 4;
  localparam int OFS_LOCK    = 5;
  localparam int OFS_PROT    = 6;

  typedef enum logic [2:0] {
    SEL_HOLD, SEL_ZERO, SEL_SHADOW, SEL_IRQ, SEL_STATUS, SEL_LOCK, SEL_PROT
  } rdSel_e;

  typedef struct packed {
    logic   wrOrig;
    logic   wrShadow;
    logic   clrIrq;
    logic   wrTx;
    logic   wrLock;
    logic   wrProt;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/regBankCtrl.sv
module regBankCtrl
  import regBankPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              lockBit,
  input  logic              hwLock,
  output strobe_t           strb
);
  logic writeLocked;
  assign writeLocked = lockBit | hwLock;

  always_comb begin
    strb = '0;
    strb.rdSel = SEL_HOLD;
    if (busWrEn) begin
      if (busAddr == ADDR_W'(OFS_ORIG)) begin
        strb.wrOrig   = 1'b1;
        strb.wrShadow = 1'b1;  // shadow decoded on the same write
      end
      if (busAddr == ADDR_W'(OFS_IRQ_W1C)) strb.clrIrq = 1'b1;
      if (busAddr == ADDR_W'(OFS_PAIR))    strb.wrTx   = 1'b1;
      if (busAddr == ADDR_W'(OFS_LOCK))    strb.wrLock = 1'b1;
      if (busAddr == ADDR_W'(OFS_PROT))    strb.wrProt = !writeLocked;
    end
    if (busRdEn) begin
      if (busAddr == ADDR_W'(OFS_SHADOW))                                    strb.rdSel = SEL_SHADOW;
      else if (busAddr == ADDR_W'(OFS_IRQ_RO) || busAddr == ADDR_W'(OFS_IRQ_W1C)) strb.rdSel = SEL_IRQ;
      else if (busAddr == ADDR_W'(OFS_PAIR))                                 strb.rdSel = SEL_STATUS;
      else if (busAddr == ADDR_W'(OFS_LOCK))                                 strb.rdSel = SEL_LOCK;
      else if (busAddr == ADDR_W'(OFS_PROT))                                 strb.rdSel = SEL_PROT;
      else                                                                   strb.rdSel = SEL_ZERO;
    end
  end
endmodule

// File: rtl/regBankDatapath.sv
module regBankDatapath
  import regBankPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] irqSet,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] cfgWord,
  output logic [DATA_W-1:0] txWord,
  output logic              lockBit
);
  logic [DATA_W-1:0] origQ, shadowQ, irqQ, txQ, lockQ, protQ, rdDataQ;
  logic [DATA_W-1:0] rdNext, irqNext, clrMask;

  assign clrMask = strb.clrIrq ? busWrData : '0;
  assign irqNext = (irqQ & ~clrMask) | irqSet;   // set beats clear

  always_comb begin
    case (strb.rdSel)
      SEL_ZERO:   rdNext = '0;
      SEL_SHADOW: rdNext = shadowQ;
      SEL_IRQ:    rdNext = irqQ;
      SEL_STATUS: rdNext = statusIn;
      SEL_LOCK:   rdNext = lockQ;
      SEL_PROT:   rdNext = protQ;
      default:    rdNext = rdDataQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      origQ   <= '0;
      shadowQ <= '0;
      irqQ    <= '0;
      txQ     <= '0;
      lockQ   <= '0;
      protQ   <= '0;
      rdDataQ <= '0;
    end else begin
      if (strb.wrOrig)   origQ   <= busWrData;
      if (strb.wrShadow) shadowQ <= busWrData;
      if (strb.wrTx)     txQ     <= busWrData;
      if (strb.wrLock)   lockQ   <= busWrData;
      if (strb.wrProt)   protQ   <= busWrData;
      irqQ    <= irqNext;
      rdDataQ <= rdNext;
    end
  end

  assign busRdData = rdDataQ;
  assign cfgWord   = origQ;
  assign txWord    = txQ;
  assign lockBit   = lockQ[0];

  p_shadow_tracks_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrOrig |=> shadowQ == origQ);
  p_irq_set_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|irqSet) |=> ((irqQ & $past(irqSet)) == $past(irqSet)));
  p_irq_no_spurious_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(|irqSet) |=> ((irqQ & ~$past(irqQ)) == '0));
  p_tx_only_on_pair_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrTx |=> $stable(txQ));
endmodule

// File: rtl/complexRegBank.sv
module complexRegBank
  import regBankPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] irqSet,
  input  logic [DATA_W-1:0] statusIn,
  input  logic              hwLock,
  output logic [DATA_W-1:0] cfgWord,
  output logic [DATA_W-1:0] txWord
);
  strobe_t strb;
  logic    lockBit;

  regBankCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .lockBit(lockBit), .hwLock(hwLock), .strb(strb)
  );

  regBankDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .irqSet(irqSet), .statusIn(statusIn), .busRdData(busRdData),
    .cfgWord(cfgWord), .txWord(txWord), .lockBit(lockBit)
  );

  p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hwLock || lockBit) |=> $stable(u_dp.protQ));
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr > ADDR_W'(OFS_PROT)) |=> busRdData == '0);
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData));
endmodule

// File: tb/complexRegBank_test.sv
module complexRegBank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0, hwLock = 1'b0;
  logic [31:0] busWrData = '0, irqSet = '0, statusIn = '0;
  logic [31:0] busRdData, cfgWord, txWord;

  int checks = 0;
  int fails = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  complexRegBank uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqSet(irqSet), .statusIn(statusIn), .hwLock(hwLock),
    .cfgWord(cfgWord), .txWord(txWord)
  );

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  // monitor: a read sampled at a rising edge is compared at the next falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (busRdEn) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          checkVal("R11 unexpected read", busRdData, 32'h0);
        end else begin
          checkVal(tagQ.pop_front(), busRdData, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 cfgWord", cfgWord, 32'h0);
    checkVal("R1 txWord", txWord, 32'h0);
    rd(4'h1, 32'h0, "R1 shadow");
    rd(4'h2, 32'h0, "R1 irq");
    rd(4'h6, 32'h0, "R1 prot");

    wr(4'h0, 32'hA5A5_1234);
    checkVal("R2 cfgWord", cfgWord, 32'hA5A5_1234);
    rd(4'h0, 32'h0, "R2 orig write-only");
    rd(4'h1, 32'hA5A5_1234, "R2 shadow copy");
    wr(4'h1, 32'hFFFF_FFFF);
    rd(4'h1, 32'hA5A5_1234, "R3 shadow write ignored");
    checkVal("R3 cfgWord", cfgWord, 32'hA5A5_1234);

    irqSet = 32'h0000_00F1; @(negedge clk); irqSet = '0;
    rd(4'h2, 32'h0000_00F1, "R4 irq ro view");
    rd(4'h4, 32'h0000_00F1, "R4 irq w1c view read");
    wr(4'h2, 32'hFFFF_FFFF);
    rd(4'h2, 32'h0000_00F1, "R4 ro view write ignored");
    wr(4'h4, 32'h0000_0011);
    rd(4'h2, 32'h0000_00E0, "R5 partial clear");
    irqSet = 32'h0000_0120;
    wr(4'h4, 32'hFFFF_FFFF);
    irqSet = '0;
    rd(4'h4, 32'h0000_0120, "R6 set beats clear");

    wr(4'h6, 32'h0000_CAFE);
    rd(4'h6, 32'h0000_CAFE, "R8 unlocked write");
    wr(4'h5, 32'h0000_0001);
    rd(4'h5, 32'h0000_0001, "R7 lock field");
    wr(4'h6, 32'h0000_BEEF);
    rd(4'h6, 32'h0000_CAFE, "R8 field lock blocks");
    wr(4'h5, 32'h0000_0000);
    rd(4'h5, 32'h0000_0000, "R7 unlock while locked");
    wr(4'h6, 32'h0000_1111);
    rd(4'h6, 32'h0000_1111, "R8 write after unlock");
    hwLock = 1'b1;
    wr(4'h6, 32'h0000_2222);
    hwLock = 1'b0;
    rd(4'h6, 32'h0000_1111, "R8 hw lock blocks");

    statusIn = 32'h1357_2468;
    rd(4'h3, 32'h1357_2468, "R9 status read");
    wr(4'h3, 32'hDEAD_BEEF);
    checkVal("R9 txWord", txWord, 32'hDEAD_BEEF);
    rd(4'h3, 32'h1357_2468, "R9 tx not readable");
    statusIn = 32'h0F0F_0F0F;
    rd(4'h3, 32'h0F0F_0F0F, "R9 status follows input");
    rd(4'h1, 32'hA5A5_1234, "R9 shadow untouched");

    rd(4'h7, 32'h0, "R10 unmapped 7");
    rd(4'hF, 32'h0, "R10 unmapped 15");
    wr(4'h7, 32'hFFFF_FFFF);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h1, 32'hA5A5_1234, "R10 shadow unchanged");
    rd(4'h5, 32'h0, "R10 lock unchanged");
    rd(4'h2, 32'h0000_0120, "R10 irq unchanged");
    rd(4'h6, 32'h0000_1111, "R10 prot unchanged");
    checkVal("R10 cfgWord", cfgWord, 32'hA5A5_1234);
    checkVal("R10 txWord", txWord, 32'hDEAD_BEEF);

    repeat (3) @(negedge clk);
    checkVal("R11 read data held", busRdData, 32'h0000_1111);
    @(negedge clk);
    checkVal("R11 queue drained", 32'(expQ.size()), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule